// File: doc/BRIEF.md
# Programmable-Length Serial Shift Engine

This block shifts a software-framed word out of a 64-bit register one bit at a time. The block drives a serial data line and a bit clock. Software writes the whole frame into the register: start, data, parity and stop bits for an asynchronous serial link, or a plain data word for an SPI peripheral. Software then programs the length of a bit cell in system clocks. Writing the bit count starts the transfer. The block adds no framing of its own.

The same storage can be reached through two host views. The plain view sends the word LSB first. The reversed view maps bit i to bit 63-i, so a word written through it goes out MSB first, which suits SPI mode 1. In the middle of each bit cell the register moves one place toward bit 0 and takes the synchronised receive input into bit 63. After an n-bit SPI exchange the received bits sit in the low n bits of the reversed view. With the output looped back to the input, the register rotates.

Top module: `serial_shift_engine`

## Requirements
- R1: After reset, `txd_o` is 1, `txc_o` is 0 and `busy_o` is 0.
- R2: A write to the count register (address 3, low 7 bits) while idle starts a transfer. `busy_o` rises on that edge and stays high for exactly n×N clocks, where n is the count and N the divisor. A count of 0 acts as 1 and a count above 64 acts as 64.
- R3: For the whole of bit cell k, `txd_o` carries the value bit 0 of the register held when that cell began, so the plain view goes out LSB first. While idle, `txd_o` is 1.
- R4: Each bit cell starts with `txc_o` high for floor(N/2) clocks, followed by `txc_o` low for the remaining clocks. `txc_o` is 0 while idle. A stored divisor of 0 or 1 acts as 2.
- R5: On the edge where `txc_o` falls, the register shifts one place toward bit 0 and bit 63 takes `rxd_i` as it stood two clock edges earlier, because of the two-flop synchroniser. While idle and not written, the register does not change.
- R6: Address 1 is the reversed view: bit i of `wr_data_i` and `rd_data_o` corresponds to register bit 63-i, for both writes and reads. After an n-bit transfer through that view, the received bits occupy its bits n-1..0, with the first bit received at bit n-1.
- R7: While `busy_o` is high, writes to every address are ignored. They change neither the register, nor the divisor, nor the count, nor the timing of the running transfer.
- R8: A 64-bit transfer sends all 64 register bits in order and leaves the register filled entirely with received bits.
- R9: Address map, read via `rd_addr_i` on `rd_data_o` combinationally: 0 is the plain register view, 1 the reversed view, 2 the divisor (low 16 bits), and 3 the stored raw count (low 7 bits). Reads of addresses 2 and 3 are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 64 | Read data for `rd_addr_i` |
| rxd_i | input | 1 | Serial receive input (MISO) |
| txd_o | output | 1 | Serial transmit output (MOSI) |
| txc_o | output | 1 | Bit clock, idle low |
| busy_o | output | 1 | Transfer in progress |

## Verification
The checker assumes the host respects the write-ignored window. It only ever relates a write strobe to register state when `busy_o` is known. It also assumes `rxd_i` may change at any time, so it never checks the received bit's value, only that the register moves as a shift. The bench changes `rxd_i` just after the clock edge that opens a bit cell. For cell-varying receive patterns it uses divisors of 6 or more, so that the synchronised sample taken at the falling `txc_o` edge belongs to the same cell. For shorter cells it holds `rxd_i` constant for the whole transfer.

// File: rtl/sse_pkg.sv
`timescale 1ns/1ps
package sse_pkg;
  typedef enum logic [1:0] {
    SSE_REG_PLAIN   = 2'd0,
    SSE_REG_REVERSE = 2'd1,
    SSE_REG_DIVISOR = 2'd2,
    SSE_REG_COUNT   = 2'd3
  } sse_reg_e;
endpackage

// File: rtl/sse_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases on the clock.
module sse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sse_bit_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for the serial receive input.
module sse_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sse_bit_rev.sv
`timescale 1ns/1ps
// Pure wiring: out[i] = in[W-1-i].
module sse_bit_rev #(
  parameter int W = 64
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign out_o[i] = in_i[W-1-i];
  end
endmodule

// File: rtl/sse_cell_timer.sv
`timescale 1ns/1ps
// Bit-cell phase counter: high half first, shift point at the falling edge.
module sse_cell_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,     // already clamped to >= 2
  output logic             shift_o,
  output logic             cell_end_o,
  output logic             clk_high_o
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic [DIV_W-1:0] half, last;
  logic             phase_en;

  assign half = div_i >> 1;
  assign last = div_i - 1'b1;

  always_comb begin
    phase_d  = phase_q;
    phase_en = start_i | run_i;
    if (start_i)              phase_d = '0;
    else if (phase_q == last) phase_d = '0;
    else                      phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign shift_o    = run_i && (phase_q == half - 1'b1);
  assign cell_end_o = run_i && (phase_q == last);
  assign clk_high_o = run_i && (phase_q < half);
endmodule

// File: rtl/serial_shift_engine.sv
`timescale 1ns/1ps
module serial_shift_engine #(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              txc_o,
  output logic              busy_o
);
  import sse_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic              rst_n_s;
  logic              rxd_s;
  logic [DATA_W-1:0] shreg_q, shreg_d, shreg_rev, wr_rev;
  logic [DIV_W-1:0]  div_q, div_d, div_eff;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_wr, cnt_eff;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              busy_q, busy_d;
  logic              txd_q, txd_d;
  logic              idle_wr, start, last_cell;
  logic              shift_pt, cell_end, clk_high;
  logic              shreg_en, div_en, cnt_en, left_en, busy_en, txd_en;
  sse_reg_e          wr_sel, rd_sel;

  sse_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync_o(rst_n_s)
  );

  sse_bit_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(rxd_i), .q_o(rxd_s)
  );

  sse_bit_rev #(.W(DATA_W)) u_rev_rd (.in_i(shreg_q),   .out_o(shreg_rev));
  sse_bit_rev #(.W(DATA_W)) u_rev_wr (.in_i(wr_data_i), .out_o(wr_rev));

  sse_cell_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .start_i(start), .run_i(busy_q),
    .div_i(div_eff), .shift_o(shift_pt), .cell_end_o(cell_end),
    .clk_high_o(clk_high)
  );

  assign wr_sel    = sse_reg_e'(wr_addr_i);
  assign rd_sel    = sse_reg_e'(rd_addr_i);
  assign idle_wr   = wr_en_i && !busy_q;
  assign start     = idle_wr && (wr_sel == SSE_REG_COUNT);
  assign div_eff   = (div_q < DIV_MIN) ? DIV_MIN : div_q;
  assign cnt_wr    = wr_data_i[CNT_W-1:0];
  assign last_cell = (left_q == CNT_W'(1));

  // Count clamp: 0 -> 1, above width -> width.
  always_comb begin
    if (cnt_wr == '0)          cnt_eff = CNT_W'(1);
    else if (cnt_wr > CNT_MAX) cnt_eff = CNT_MAX;
    else                       cnt_eff = cnt_wr;
  end

  // Host register next state.
  always_comb begin
    div_d  = div_q;
    div_en = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (idle_wr && wr_sel == SSE_REG_DIVISOR) begin
      div_d  = wr_data_i[DIV_W-1:0];
      div_en = 1'b1;
    end
    if (start) begin
      cnt_d  = cnt_wr;
      cnt_en = 1'b1;
    end
  end

  // Shift register next state: host write when idle, shift at falling bit clock.
  always_comb begin
    shreg_d  = shreg_q;
    shreg_en = 1'b0;
    if (idle_wr && wr_sel == SSE_REG_PLAIN) begin
      shreg_d  = wr_data_i;
      shreg_en = 1'b1;
    end else if (idle_wr && wr_sel == SSE_REG_REVERSE) begin
      shreg_d  = wr_rev;
      shreg_en = 1'b1;
    end else if (shift_pt) begin
      shreg_d  = {rxd_s, shreg_q[DATA_W-1:1]};
      shreg_en = 1'b1;
    end
  end

  // Transfer control next state.
  always_comb begin
    busy_d  = busy_q;
    busy_en = 1'b0;
    left_d  = left_q;
    left_en = 1'b0;
    txd_d   = txd_q;
    txd_en  = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      busy_en = 1'b1;
      left_d  = cnt_eff;
      left_en = 1'b1;
      txd_d   = shreg_q[0];
      txd_en  = 1'b1;
    end else if (cell_end) begin
      if (last_cell) begin
        busy_d  = 1'b0;
        busy_en = 1'b1;
        txd_d   = 1'b1;
        txd_en  = 1'b1;
      end else begin
        left_d  = left_q - 1'b1;
        left_en = 1'b1;
        txd_d   = shreg_q[0];
        txd_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      shreg_q <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      if (shreg_en) shreg_q <= shreg_d;
      if (div_en)   div_q   <= div_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (left_en)  left_q  <= left_d;
      if (busy_en)  busy_q  <= busy_d;
      if (txd_en)   txd_q   <= txd_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SSE_REG_PLAIN:   rd_data_o = shreg_q;
      SSE_REG_REVERSE: rd_data_o = shreg_rev;
      SSE_REG_DIVISOR: rd_data_o = DATA_W'(div_q);
      SSE_REG_COUNT:   rd_data_o = DATA_W'(cnt_q);
      default:         rd_data_o = '0;
    endcase
  end

  assign txd_o  = busy_q ? txd_q : 1'b1;
  assign txc_o  = clk_high;
  assign busy_o = busy_q;
endmodule

// File: rtl/sse_checker.sv
`timescale 1ns/1ps
module sse_checker #(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic              txd,
  input logic              txc,
  input logic [DIV_W-1:0]  div_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] shreg_q
);
  assert_idle_txd_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_idle_txc_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !txc);

  assert_start_clock_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> txc);

  assert_txd_steady_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txc && $past(busy) && $past(txc)) |-> $stable(txd));

  assert_shift_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(txc)) |-> (shreg_q[DATA_W-2:0] == $past(shreg_q[DATA_W-1:1])));

  assert_idle_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(shreg_q));

  assert_busy_div_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_q));

  assert_busy_cnt_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cnt_q));
endmodule

bind serial_shift_engine sse_checker #(
  .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
) u_sse_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .busy(busy_o), .txd(txd_o),
  .txc(txc_o), .div_q(div_q), .cnt_q(cnt_q), .shreg_q(shreg_q)
);

// File: tb/tb_serial_shift_engine.sv
`timescale 1ns/1ps
module tb_serial_shift_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [63:0] rd_data_o;
  logic        rxd_i = 1'b1;
  logic        txd_o, txc_o, busy_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  serial_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rxd_i(rxd_i), .txd_o(txd_o), .txc_o(txc_o), .busy_o(busy_o)
  );

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  // One transfer through the given view; rx_bits[k] is driven during cell k.
  task automatic run_xfer(input string req, input bit rev_view,
                          input logic [63:0] data, input int cnt, input int div,
                          input logic [63:0] rx_bits, input bit poke);
    int n, nd, h;
    logic [63:0] model, got;
    logic exp_bit;
    n  = (cnt == 0) ? 1 : ((cnt > 64) ? 64 : cnt);
    nd = (div < 2) ? 2 : div;
    h  = nd / 2;
    model = rev_view ? rev64(data) : data;
    rxd_i = rx_bits[0];
    wr(2'd2, 64'(div));
    wr(rev_view ? 2'd1 : 2'd0, data);
    wr(2'd3, 64'(cnt));
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < nd; p++) begin
        if (!(k == 0 && p == 0)) @(negedge clk);
        if (p == 0) begin
          rxd_i   = rx_bits[k];
          exp_bit = model[0];
        end
        if (p == h) model = {rx_bits[k], model[63:1]};
        if (poke && k == 0) begin
          if (p == 0) begin wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 64'd7; end
          if (p == 1) begin wr_addr_i = 2'd0; wr_data_i = '1; end
          if (p == 2) begin wr_addr_i = 2'd3; wr_data_i = 64'd1; end
          if (p == 3) wr_en_i = 1'b0;
        end
        chk(busy_o == 1'b1, {req, " busy during transfer"}, 64'(busy_o), 64'd1);
        chk(txc_o == (p < h), {req, " txc phase"}, 64'(txc_o), 64'(p < h));
        chk(txd_o == exp_bit, {req, " txd bit"}, 64'(txd_o), 64'(exp_bit));
      end
    end
    @(negedge clk);
    chk(busy_o == 1'b0, {req, " R2 busy ends"}, 64'(busy_o), 64'd0);
    chk(txd_o == 1'b1, {req, " R3 txd idle high"}, 64'(txd_o), 64'd1);
    chk(txc_o == 1'b0, {req, " R4 txc idle low"}, 64'(txc_o), 64'd0);
    rd(rev_view ? 2'd1 : 2'd0, got);
    chk(got == (rev_view ? rev64(model) : model), {req, " R5 readback"}, got,
        rev_view ? rev64(model) : model);
  endtask

  task automatic t_reset();
    chk(txd_o == 1'b1, "R1 txd", 64'(txd_o), 64'd1);
    chk(txc_o == 1'b0, "R1 txc", 64'(txc_o), 64'd0);
    chk(busy_o == 1'b0, "R1 busy", 64'(busy_o), 64'd0);
  endtask

  task automatic t_views();
    logic [63:0] v, d;
    d = 64'h0123_4567_89AB_CDEF;
    wr(2'd0, d);
    rd(2'd1, v);
    chk(v == rev64(d), "R6 plain write reversed read", v, rev64(d));
    wr(2'd1, d);
    rd(2'd0, v);
    chk(v == rev64(d), "R6 reversed write plain read", v, rev64(d));
    wr(2'd2, 64'h0001_0000_0000_ABCD);
    rd(2'd2, v);
    chk(v == 64'hABCD, "R9 divisor readback", v, 64'hABCD);
  endtask

  task automatic t_uart_8n1();
    logic [63:0] frame, v;
    frame = {54'h3F_FFFF_FFFF_FFFF, 1'b1, 8'hA5, 1'b0};
    run_xfer("R3 uart 8N1", 1'b0, frame, 10, 6, 64'h0000_0000_0000_02D3, 1'b0);
    rd(2'd3, v);
    chk(v == 64'd10, "R9 count readback", v, 64'd10);
  endtask

  task automatic t_odd_div();
    run_xfer("R4 odd divisor", 1'b0, 64'h5, 3, 5, '1, 1'b0);
  endtask

  task automatic t_zero_cfg();
    run_xfer("R2 R4 zero count and divisor", 1'b0, 64'h0, 0, 0, '1, 1'b0);
    run_xfer("R4 divisor one", 1'b0, 64'h1, 2, 1, '0, 1'b0);
  endtask

  task automatic t_full64();
    run_xfer("R8 64-bit transfer", 1'b0, 64'hF00D_CAFE_1234_8001, 64, 3, '1, 1'b0);
    run_xfer("R2 count clamp 100", 1'b0, 64'h8000_0000_0000_0001, 100, 2, '0, 1'b0);
  endtask

  task automatic t_spi();
    logic [63:0] v;
    run_xfer("R6 spi msb first", 1'b1, {8'hC3, 56'h0}, 8, 8,
             64'h0000_0000_0000_005A, 1'b0);
    rd(2'd1, v);
    chk(v[7:0] == 8'h5A, "R6 spi received low bits", 64'(v[7:0]), 64'h5A);
  endtask

  task automatic t_busy_writes();
    logic [63:0] v;
    run_xfer("R7 writes while busy", 1'b0, 64'h0F0F_0000_0000_00C6, 4, 6,
             64'h0000_0000_0000_0009, 1'b1);
    rd(2'd2, v);
    chk(v == 64'd6, "R7 divisor unchanged", v, 64'd6);
    rd(2'd3, v);
    chk(v == 64'd4, "R7 count unchanged", v, 64'd4);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("[TB] watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_views();
    t_uart_8n1();
    t_odd_div();
    t_zero_cfg();
    t_full64();
    t_spi();
    t_busy_writes();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule